// File: doc/BRIEF.md
# Repeat-Mode DMA Transfer Channel

A single DMA channel that copies data across a 20-bit address space through a plain bus master port with separate read and write strobes and a 16-bit data path. Software fills in a source address, a destination address, a count reload value and a control word, then turns on the enable bit. Every request moves one unit (byte or word) as a read cycle followed by a write cycle and a dummy cycle. Requests come either from a software write or from an external request pulse.

The channel keeps a working count and a working address for the side that advances. It reloads both when it starts for the first time after being enabled, and again after every wrap of the count. A wrap of the count raises an interrupt flag and leaves the channel enabled, so the copy loops for as long as requests keep coming. Software clears the flag by writing zero to it or through an acknowledge input.

Registers are written through `reg_we`/`reg_addr`/`reg_wdata`. Index 0 holds the source address, 1 the destination address and 2 the reload count. Index 3 is the control word: bit 0 enable, bit 1 word unit, bits 3:2 addressing option, bit 4 software trigger select. Index 4 is the software request (bit 0) and index 5 the interrupt flag (bit 0).

Top module: `dma_rpt`

## Requirements
- R1: With control bit 4 set, a write of 1 to bit 0 of register 4 latches a request. With bit 4 clear, only a one-cycle `ext_req` pulse latches a request, and software request writes have no effect.
- R2: The first transfer after enable goes from 0 to 1 loads the working count from register 2. It also loads the working address from register 0, or from register 1 when the addressing option is 1.
- R3: Each request performs exactly one read-write-dummy transfer. The working count then drops by one and the working address advances by 1 for bytes or 2 for words.
- R4: When a transfer runs with working count 0, the count wraps to all ones and `irq` is set on the same clock edge. The enable bit stays 1, so later requests still transfer.
- R5: The first transfer after a wrap reloads the count and the working address, as in R2.
- R6: Control bit 1 picks the unit: 0 is byte, 1 is word, and `bus_word` shows it. A byte transfer writes the low 8 bits of the read data with the upper lane zero. A word transfer writes all 16 bits.
- R7: A transfer is one `bus_rd` cycle, then one `bus_wr` cycle, then one dummy cycle with neither strobe active. `busy` is high for exactly these three cycles. The read cycle comes in the cycle after the request is latched.
- R8: Addressing option (control bits 3:2) 0 advances the source with a fixed destination. Option 1 keeps the source fixed and advances the destination. Options 2 and 3 keep both fixed. Advancing addresses wrap modulo 2^20.
- R9: `irq` clears on an `irq_ack` pulse or on a write of 0 to bit 0 of register 5. A write of 1 there leaves it unchanged.
- R10: With reload value 1, each loop has two transfers. After them the count reads 0 and then all ones (0xFF with an 8-bit count).
- R11: A request that arrives during a transfer is kept and served after the dummy cycle. The latch clears when its transfer starts.
- R12: While the enable bit is 0, no transfer starts. A request latched in that time is served once the channel is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | AW | Register write data |
| ext_req | input | 1 | External request pulse |
| irq_ack | input | 1 | Interrupt acknowledge, clears irq |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_word | output | 1 | 1 for a 16-bit unit, 0 for a byte |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled at the end of the read cycle |
| busy | output | 1 | Channel owns the bus |
| irq | output | 1 | Interrupt request flag |
| cur_count | output | CW | Working transfer count |

## Verification
The bench builds the channel with an 8-bit count (CW=8) and the default 20-bit address and 16-bit data. With the narrow count, a wrap from 0x00 to 0xFF takes only a few transfers, so the reload-of-1 loop and the repeated wrap with reload 0 can both be checked. The full 20-bit address lets the bench start a word copy at 0xFFFFE and see the working address roll over to 0x00000.

// File: rtl/dma_rpt.sv
module dma_rpt #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  input  logic          ext_req,
  input  logic          irq_ack,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_word,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          irq,
  output logic [CW-1:0] cur_count
);
  localparam int HW = DW / 2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DUM} st_t;
  st_t st;

  logic [AW-1:0] src_q, dst_q, ptr_q;
  logic [CW-1:0] rld_q, cnt_q;
  logic [DW-1:0] dat_q;
  logic [1:0]    mode_q;
  logic en_q, word_q, swtrg_q, fresh_q, pend_q, irq_q;

  wire wr_ctl  = reg_we && reg_addr == 3'd3;
  wire sw_hit  = reg_we && reg_addr == 3'd4 && reg_wdata[0] && swtrg_q;
  wire ext_hit = ext_req && !swtrg_q;
  wire irq_clr = irq_ack || (reg_we && reg_addr == 3'd5 && !reg_wdata[0]);
  wire start   = st == S_IDLE && en_q && pend_q;
  wire under   = st == S_WR && cnt_q == '0;
  wire inc_src = mode_q == 2'd0;
  wire inc_dst = mode_q == 2'd1;
  wire [AW-1:0] base = inc_dst ? dst_q : src_q;
  wire [AW-1:0] step = word_q ? AW'(2) : AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; rld_q <= '0;
      en_q <= 1'b0; word_q <= 1'b0; mode_q <= 2'd0; swtrg_q <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: src_q <= reg_wdata;
        3'd1: dst_q <= reg_wdata;
        3'd2: rld_q <= reg_wdata[CW-1:0];
        3'd3: begin
          en_q    <= reg_wdata[0];
          word_q  <= reg_wdata[1];
          mode_q  <= reg_wdata[3:2];
          swtrg_q <= reg_wdata[4];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      fresh_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      pend_q  <= (pend_q && !start) || sw_hit || ext_hit;
      fresh_q <= (fresh_q && !start) || under || (wr_ctl && reg_wdata[0] && !en_q);
      irq_q   <= under || (irq_q && !irq_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt_q <= '0;
      ptr_q <= '0;
      dat_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_RD;
          if (fresh_q) begin
            cnt_q <= rld_q;
            ptr_q <= base;
          end
        end
        S_RD: begin
          st    <= S_WR;
          dat_q <= word_q ? bus_rdata : {{(DW-HW){1'b0}}, bus_rdata[HW-1:0]};
        end
        S_WR: begin
          st    <= S_DUM;
          cnt_q <= cnt_q - 1'b1;
          if (inc_src || inc_dst) ptr_q <= ptr_q + step;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_rd    = st == S_RD;
  assign bus_wr    = st == S_WR;
  assign bus_addr  = bus_rd ? (inc_dst ? src_q : ptr_q) :
                     bus_wr ? (inc_dst ? ptr_q : dst_q) : '0;
  assign bus_wdata = bus_wr ? dat_q : '0;
  assign bus_word  = word_q;
  assign busy      = st != S_IDLE;
  assign irq       = irq_q;
  assign cur_count = cnt_q;
endmodule

// File: rtl/dma_rpt_chk.sv
module dma_rpt_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          busy,
  input logic          irq,
  input logic          irq_ack,
  input logic [CW-1:0] cur_count
);
  AST_RD_TO_WR: assert property (@(posedge clk) disable iff (!rst_n) bus_rd |=> bus_wr); // R7
  AST_WR_TO_DUMMY: assert property (@(posedge clk) disable iff (!rst_n) bus_wr |=> (busy && !bus_rd && !bus_wr)); // R7
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R7
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd || bus_wr) |-> busy); // R7
  AST_UNDERFLOW_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && cur_count == '0) |=> (irq && cur_count == '1)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && cur_count != '0) |=> cur_count == CW'($past(cur_count) - 1'b1)); // R3
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n) (irq && irq_ack && !(bus_wr && cur_count == '0)) |=> !irq); // R9
endmodule

bind dma_rpt dma_rpt_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .busy(busy),
  .irq(irq), .irq_ack(irq_ack), .cur_count(cur_count)
);

// File: tb/dma_rpt_test.sv
module dma_rpt_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [19:0] reg_wdata = '0;
  logic ext_req = 1'b0, irq_ack = 1'b0;
  logic [19:0] bus_addr;
  logic bus_rd, bus_wr, bus_word, busy, irq;
  logic [15:0] bus_wdata, bus_rdata;
  logic [7:0] cur_count;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] mem(input logic [19:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] ^ a[7:0]};
  endfunction
  assign bus_rdata = mem(bus_addr);

  dma_rpt #(.AW(20), .DW(16), .CW(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ext_req(ext_req), .irq_ack(irq_ack), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .irq(irq),
    .cur_count(cur_count)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  function automatic logic [19:0] ctl(input bit en, input bit word, input logic [1:0] mode, input bit sw);
    return {15'd0, sw, mode, word, en};
  endfunction

  task automatic setup(input logic [19:0] s, input logic [19:0] d, input logic [7:0] r, input logic [19:0] c);
    wr(3, 20'd0); wr(0, s); wr(1, d); wr(2, {12'd0, r}); wr(5, 20'd0); wr(3, c);
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (busy) seen = 1'b1; end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic do_one(input bit req, input logic [19:0] ea_rd, input logic [19:0] ea_wr,
                        input logic [15:0] ed, input logic [7:0] ecnt, input bit eirq, input string tag);
    if (req) wr(4, 20'd1);
    for (int i = 0; i < 6 && !bus_rd; i++) @(negedge clk);
    chk(bus_rd && busy, {tag, " R7 read"}, bus_rd, 1);
    chk(bus_addr == ea_rd, {tag, " R8 read addr"}, bus_addr, ea_rd);
    @(negedge clk);
    chk(bus_wr && !bus_rd, {tag, " R7 write"}, bus_wr, 1);
    chk(bus_addr == ea_wr, {tag, " R8 write addr"}, bus_addr, ea_wr);
    chk(bus_wdata == ed, {tag, " R6 data"}, bus_wdata, ed);
    @(negedge clk);
    chk(busy && !bus_rd && !bus_wr, {tag, " R7 dummy"}, {busy, bus_rd, bus_wr}, 3'b100);
    chk(cur_count == ecnt, {tag, " R3 count"}, cur_count, ecnt);
    chk(irq == eirq, {tag, " R4 irq"}, irq, eirq);
    @(negedge clk);
    chk(!busy, {tag, " R7 idle"}, busy, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !irq && !bus_rd && !bus_wr, "reset state", {busy, irq, bus_rd, bus_wr}, 0);
  endtask

  task automatic t_src_inc;
    setup(20'h10000, 20'h00300, 8'd1, ctl(1, 1, 2'd0, 1));
    do_one(1, 20'h10000, 20'h00300, mem(20'h10000), 8'h00, 0, "R2 R10 first");
    do_one(1, 20'h10002, 20'h00300, mem(20'h10002), 8'hFF, 1, "R4 R10 wrap");
    do_one(1, 20'h10000, 20'h00300, mem(20'h10000), 8'h00, 1, "R5 reload");
    wr(5, 20'd1);
    chk(irq, "R9 write 1 keeps irq", irq, 1);
    wr(5, 20'd0);
    chk(!irq, "R9 write 0 clears", irq, 0);
    do_one(1, 20'h10002, 20'h00300, mem(20'h10002), 8'hFF, 1, "R4 second wrap");
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk(!irq, "R9 ack clears", irq, 0);
  endtask

  task automatic t_dst_inc_byte;
    logic [15:0] b = {8'h00, mem(20'h00040) & 16'h00FF} & 16'h00FF;
    setup(20'h00040, 20'h20000, 8'd2, ctl(1, 0, 2'd1, 1));
    chk(!bus_word, "R6 byte unit", bus_word, 0);
    do_one(1, 20'h00040, 20'h20000, b, 8'h01, 0, "R6 R8 dst inc 0");
    do_one(1, 20'h00040, 20'h20001, b, 8'h00, 0, "R8 dst inc 1");
    do_one(1, 20'h00040, 20'h20002, b, 8'hFF, 1, "R4 dst inc wrap");
    do_one(1, 20'h00040, 20'h20000, b, 8'h01, 1, "R5 dst reload");
  endtask

  task automatic t_fixed;
    setup(20'h00500, 20'h00600, 8'd0, ctl(1, 1, 2'd2, 1));
    do_one(1, 20'h00500, 20'h00600, mem(20'h00500), 8'hFF, 1, "R8 fixed a");
    wr(5, 20'd0);
    do_one(1, 20'h00500, 20'h00600, mem(20'h00500), 8'hFF, 1, "R8 fixed b");
  endtask

  task automatic t_ext;
    setup(20'h00700, 20'h00800, 8'd5, ctl(1, 1, 2'd2, 0));
    wr(4, 20'd1);
    quiet(6, "R1 sw write ignored in ext mode");
    @(negedge clk); ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
    do_one(0, 20'h00700, 20'h00800, mem(20'h00700), 8'h04, 0, "R1 ext pulse");
  endtask

  task automatic t_pending;
    int rds = 0;
    setup(20'h00900, 20'h00A00, 8'd9, ctl(1, 1, 2'd2, 1));
    wr(4, 20'd1);
    for (int i = 0; i < 6 && !bus_rd; i++) @(negedge clk);
    chk(bus_rd, "R11 first transfer", bus_rd, 1);
    wr(4, 20'd1);
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (bus_rd) rds++; end
    chk(rds == 1, "R11 held request served once", rds, 1);
    chk(cur_count == 8'd7, "R11 count after two", cur_count, 7);
  endtask

  task automatic t_disable;
    setup(20'h03000, 20'h00400, 8'd3, ctl(1, 1, 2'd0, 1));
    do_one(1, 20'h03000, 20'h00400, mem(20'h03000), 8'h02, 0, "R3 step a");
    do_one(1, 20'h03002, 20'h00400, mem(20'h03002), 8'h01, 0, "R3 step b");
    wr(3, ctl(0, 1, 2'd0, 1));
    wr(4, 20'd1);
    quiet(6, "R12 disabled no transfer");
    wr(3, ctl(1, 1, 2'd0, 1));
    do_one(0, 20'h03000, 20'h00400, mem(20'h03000), 8'h02, 0, "R2 R12 reenable reload");
  endtask

  task automatic t_wrap;
    setup(20'hFFFFE, 20'h00100, 8'd1, ctl(1, 1, 2'd0, 1));
    do_one(1, 20'hFFFFE, 20'h00100, mem(20'hFFFFE), 8'h00, 0, "R8 top");
    do_one(1, 20'h00000, 20'h00100, mem(20'h00000), 8'hFF, 1, "R8 addr wrap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_src_inc();
    t_dst_inc_byte();
    t_fixed();
    t_ext();
    t_pending();
    t_disable();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule